// File: doc/BRIEF.md
# GPIO Line Interrupt Controller

This block watches a bank of external input lines and turns selected conditions on them into a single interrupt request for a parent interrupt controller. Software gives each line one of five trigger conditions: a rising edge, a falling edge, either edge, a high level or a low level. It unmasks the lines it wants to hear from. On each interrupt it reads one status word that shows every pending line.

Each input first passes through a two-stage synchroniser. A per-line detector then compares the synchronised value with its value one clock earlier. A detected condition latches a pending bit, whether or not the line is unmasked. Pending bits stay set until software writes 1 to them. The interrupt output is high while any pending bit is also unmasked.

The register bus is a plain address, write data, write enable and combinational read data interface. The asynchronous reset is released in step with the clock inside the block.

Top module: `gpio_line_irq`

## Requirements
- R1: After reset, every mapped register reads 0 and `irq_out` is 0.
- R2: The trigger fields live in four words at 0x200, 0x204, 0x208 and 0x20C. Line n uses the word at 0x200 + 4*(n/8), bits (n mod 8)*4 up to (n mod 8)*4+3. Every bit of these words reads back as written.
- R3: Trigger codes are 0 = rising edge, 1 = falling edge, 2 = high level, 3 = low level and 4 = both edges. A line change that meets its code sets status bit n no later than the third clock edge after the change.
- R4: Trigger codes 5 to 15 never set a pending bit, whatever the line does.
- R5: The mask word at 0x210 has bit n = 1 to unmask line n. `irq_out` is 1 exactly when some bit is 1 in both the status word and the mask word.
- R6: The status word at 0x214 is write-1-to-clear. A 1 in the write data clears that bit, and a 0 leaves it as it is.
- R7: A detection sets its pending bit even while the line is masked. Writing the mask word never changes the status word.
- R8: If a detection and a write-1-to-clear hit the same bit in the same cycle, the bit stays set. A level condition that is held therefore survives a clear.
- R9: Reads from any unmapped or unaligned address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| line_in | input | 32 | Asynchronous external lines |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench runs each trigger code against both matching and non-matching transitions. A detector with its polarity swapped, or one that treats the both-edges code as a single edge, would latch the wrong lines. It also checks that reserved codes stay silent. A decoder that falls through to an edge mode would set pending bits there.

Several separate behaviours are probed at the ports:
- A line caught while masked must raise the output as soon as it is unmasked.
- Masking it again must drop the output without losing the pending bit.
- Writing zeros to the status word must change nothing.
- A held level must survive a clear.

A design that let clear win over set, or that cleared status on a mask write, would fail these probes. Field placement in the second and last trigger words is read back to catch an off-by-one in the word or nibble decode.

// File: rtl/gpio_line_irq_pkg.sv
package gpio_line_irq_pkg;
  localparam int unsigned MODE_W = 4;

  localparam logic [MODE_W-1:0] TRIG_RISE = 4'd0;
  localparam logic [MODE_W-1:0] TRIG_FALL = 4'd1;
  localparam logic [MODE_W-1:0] TRIG_HIGH = 4'd2;
  localparam logic [MODE_W-1:0] TRIG_LOW  = 4'd3;
  localparam logic [MODE_W-1:0] TRIG_BOTH = 4'd4;

  localparam logic [11:0] OFF_TRIG_BASE = 12'h200;
  localparam logic [11:0] OFF_MASK      = 12'h210;
  localparam logic [11:0] OFF_PEND      = 12'h214;
endpackage

// File: rtl/gpio_line_sync.sv
module gpio_line_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q, cur_q, prev_q;
  logic [WIDTH-1:0] meta_d, cur_d, prev_d;

  always_comb begin
    meta_d = async_in;
    cur_d  = meta_q;
    prev_d = cur_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect
  import gpio_line_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              cur_i,
  input  logic              prev_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              hit_o
);
  always_comb begin
    unique case (mode_i)
      TRIG_RISE: hit_o = cur_i & ~prev_i;
      TRIG_FALL: hit_o = ~cur_i & prev_i;
      TRIG_HIGH: hit_o = cur_i;
      TRIG_LOW:  hit_o = ~cur_i;
      TRIG_BOTH: hit_o = cur_i ^ prev_i;
      default:   hit_o = 1'b0;
    endcase
  end

  // Edge codes only fire when the synchronised line changed.
  assert_edge_needs_change_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit_o && (mode_i == TRIG_RISE || mode_i == TRIG_FALL || mode_i == TRIG_BOTH))
      |-> (cur_i != prev_i));

  assert_reserved_silent_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_i > TRIG_BOTH) |-> !hit_o);
endmodule

// File: rtl/gpio_line_regs.sv
module gpio_line_regs
  import gpio_line_irq_pkg::*;
#(
  parameter int unsigned LINES  = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic                    we_i,
  output logic [DATA_W-1:0]       rdata_o,
  input  logic [LINES-1:0]        set_i,
  output logic [LINES*MODE_W-1:0] modes_o,
  output logic                    irq_o
);
  localparam int unsigned PER_WORD = DATA_W / MODE_W;
  localparam int unsigned NWORDS   = LINES / PER_WORD;

  logic [DATA_W-1:0] trig_q [NWORDS];
  logic [DATA_W-1:0] trig_d [NWORDS];
  logic [LINES-1:0]  mask_q, mask_d, pend_q, pend_d, clr_vec;

  // Next-state process
  always_comb begin
    for (int w = 0; w < NWORDS; w++) begin
      trig_d[w] = trig_q[w];
      if (we_i && addr_i == ADDR_W'(OFF_TRIG_BASE + 4*w)) trig_d[w] = wdata_i;
    end
    mask_d  = (we_i && addr_i == ADDR_W'(OFF_MASK)) ? wdata_i[LINES-1:0] : mask_q;
    clr_vec = (we_i && addr_i == ADDR_W'(OFF_PEND)) ? wdata_i[LINES-1:0] : '0;
    pend_d  = (pend_q & ~clr_vec) | set_i;
  end

  // Register process
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NWORDS; w++) trig_q[w] <= '0;
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      for (int w = 0; w < NWORDS; w++) trig_q[w] <= trig_d[w];
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  generate
    for (genvar g = 0; g < NWORDS; g++) begin : g_modes
      assign modes_o[g*DATA_W +: DATA_W] = trig_q[g];
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NWORDS; w++)
      if (addr_i == ADDR_W'(OFF_TRIG_BASE + 4*w)) rdata_o = trig_q[w];
    if (addr_i == ADDR_W'(OFF_MASK)) rdata_o = DATA_W'(mask_q);
    if (addr_i == ADDR_W'(OFF_PEND)) rdata_o = DATA_W'(pend_q);
  end

  assign irq_o = |(pend_q & mask_q);

  // A detection in the previous cycle is never lost to a clear.
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ((~pend_q & $past(set_i)) == '0));

  // Pending bits only rise from a detection.
  assert_pend_from_set_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_i)) == '0));

  // Pending bits only fall through a write-1-to-clear, never through a mask write.
  assert_only_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ((~pend_q & $past(pend_q) & ~$past(clr_vec)) == '0));

  assert_mask_keeps_pend_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFF_MASK)) |=> ((~pend_q & $past(pend_q)) == '0));
endmodule

// File: rtl/gpio_line_irq.sv
module gpio_line_irq
  import gpio_line_irq_pkg::*;
#(
  parameter int unsigned LINES  = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [LINES-1:0]  line_in,
  output logic              irq_out
);
  logic rst_meta_q, rst_ni;
  logic [LINES-1:0] cur, prev, hit;
  logic [LINES*MODE_W-1:0] modes;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ni     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ni     <= rst_meta_q;
    end
  end

  gpio_line_sync #(.WIDTH(LINES)) u_sync (
    .clk(clk), .rst_ni(rst_ni), .async_in(line_in), .cur_o(cur), .prev_o(prev)
  );

  generate
    for (genvar n = 0; n < LINES; n++) begin : g_line
      gpio_line_detect u_det (
        .clk(clk), .rst_ni(rst_ni), .cur_i(cur[n]), .prev_i(prev[n]),
        .mode_i(modes[n*MODE_W +: MODE_W]), .hit_o(hit[n])
      );
    end
  endgenerate

  gpio_line_regs #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .we_i(bus_we), .rdata_o(bus_rdata), .set_i(hit), .modes_o(modes),
    .irq_o(irq_out)
  );
endmodule

// File: tb/gpio_line_irq_test.sv
module gpio_line_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;
  // {mode[3:0], level before, level after, expected pending}
  localparam logic [6:0] VECS [NVEC] = '{
    {4'd0, 1'b0, 1'b1, 1'b1}, {4'd0, 1'b1, 1'b0, 1'b0},
    {4'd1, 1'b1, 1'b0, 1'b1}, {4'd1, 1'b0, 1'b1, 1'b0},
    {4'd2, 1'b0, 1'b1, 1'b1}, {4'd2, 1'b0, 1'b0, 1'b0},
    {4'd3, 1'b1, 1'b0, 1'b1}, {4'd3, 1'b1, 1'b1, 1'b0},
    {4'd4, 1'b0, 1'b1, 1'b1}, {4'd4, 1'b1, 1'b0, 1'b1},
    {4'd4, 1'b1, 1'b1, 1'b0}, {4'd7, 1'b0, 1'b1, 1'b0},
    {4'd15, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic bus_we;
  logic [31:0] line_in;
  logic irq_out;
  int checks = 0, errors = 0;
  bit done = 0;

  gpio_line_irq uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .line_in(line_in), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Read-modify-write of one line's trigger field; the line may change in the same cycle.
  task automatic set_mode(int ln, logic [3:0] m, bit drive, bit lvl);
    logic [31:0] v;
    logic [11:0] a;
    a = 12'h200 + 12'(4 * (ln / 8));
    rd(a, v);
    v[(ln % 8) * 4 +: 4] = m;
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_we = 1'b1;
    if (drive) line_in[ln] = lvl;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; line_in = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(12'h200 + 12'(4 * a), v);
      check("R1 reset value", v, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irq_out}, 32'h0);

    // R2: field position and readback
    wr(12'h204, 32'h0000_00F0);
    rd(12'h204, v); check("R2 line 9 field in 0x204", v, 32'h0000_00F0);
    wr(12'h20C, 32'h4000_0000);
    rd(12'h20C, v); check("R2 line 31 field in 0x20C", v, 32'h4000_0000);
    wr(12'h204, 32'h0); wr(12'h20C, 32'h0);

    // R9: unmapped and unaligned reads
    rd(12'h000, v); check("R9 read 0x000", v, 32'h0);
    rd(12'h218, v); check("R9 read 0x218", v, 32'h0);
    wr(12'h210, 32'hFFFF_FFFF);
    rd(12'h211, v); check("R9 unaligned read 0x211", v, 32'h0);
    wr(12'h210, 32'h0);

    // R3, R4, R5: vector table, one line per vector
    for (int i = 0; i < NVEC; i++) begin
      int ln;
      logic [3:0] m;
      logic pre, post, exp;
      ln = 2 * i;
      {m, pre, post, exp} = VECS[i];
      set_mode(ln, 4'd15, 1'b0, 1'b0);
      line_in[ln] = pre;
      wait_cyc(4);
      wr(12'h214, 32'hFFFF_FFFF);
      wr(12'h210, 32'h1 << ln);
      set_mode(ln, m, 1'b1, post);
      wait_cyc(5);
      rd(12'h214, v);
      check((m > 4) ? "R4 reserved code pending" : "R3 trigger pending",
            {31'b0, v[ln]}, {31'b0, exp});
      check("R5 irq follows pending and mask", {31'b0, irq_out}, {31'b0, exp});
    end

    // R7, R5, R6: pending while masked
    wr(12'h210, 32'h0);
    set_mode(31, 4'd0, 1'b0, 1'b0);
    wr(12'h214, 32'h8000_0000);
    line_in[31] = 1'b1;
    wait_cyc(5);
    rd(12'h214, v); check("R7 pending set while masked", {31'b0, v[31]}, 32'h1);
    check("R5 irq low while masked", {31'b0, irq_out}, 32'h0);
    wr(12'h210, 32'h8000_0000);
    #1 check("R5 irq rises on unmask", {31'b0, irq_out}, 32'h1);
    wr(12'h210, 32'h0);
    #1 check("R5 irq drops on mask", {31'b0, irq_out}, 32'h0);
    rd(12'h214, v); check("R7 mask keeps pending", {31'b0, v[31]}, 32'h1);
    wr(12'h214, 32'h0);
    rd(12'h214, v); check("R6 zero write keeps pending", {31'b0, v[31]}, 32'h1);
    wr(12'h214, 32'h8000_0000);
    rd(12'h214, v); check("R6 one write clears", {31'b0, v[31]}, 32'h0);

    // R8: held level survives a clear
    set_mode(30, 4'd2, 1'b1, 1'b1);
    wait_cyc(5);
    wr(12'h214, 32'h4000_0000);
    rd(12'h214, v); check("R8 held level survives clear", {31'b0, v[30]}, 32'h1);
    line_in[30] = 1'b0;
    wait_cyc(5);
    wr(12'h214, 32'h4000_0000);
    rd(12'h214, v); check("R8 clear after level drops", {31'b0, v[30]}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule